// File: doc/BRIEF.md
# Selectable-Tick Timestamp Counter

This block keeps a free-running timestamp that software reads over a simple register bus. A single configuration word picks how fast the timestamp advances: in nanosecond units (advancing by a fixed step every system clock, 20 ns at 50 MHz), in microseconds, or in milliseconds. The block derives the microsecond and millisecond tick enables itself from the system clock, using a two-stage prescaler.

Software zeroes the timestamp by writing the configuration word with the hold bit set and then writing it again with the bit clear. While the hold bit is set the count stays at zero and the selected tick source is kept. Changing the tick source keeps the current count and restarts the prescaler, so the first tick at the new rate comes one full period later. A tick-source code the block does not know freezes the count.

Top module: `ts_timer`

## Requirements
- R1: After reset the configuration reads 0 (nanosecond source, not held) and the count is 0. Read data is registered: a read strobe sampled at a clock edge returns, after that edge, the register value from before that edge.
- R2: With source code 0 the count grows by NS_STEP (default 20) on every clock edge.
- R3: With source code 1 the count grows by 1 every US_CYCLES clocks (default 50), counted from the last prescaler restart.
- R4: With source code 2 the count grows by 1 every US_CYCLES*MS_PER_US clocks (default 50,000), counted from the last prescaler restart.
- R5: A configuration write with bit 8 set makes the count 0 at that write's edge. The count stays 0 as long as bit 8 remains set.
- R6: A configuration write with bit 8 clear that follows a hold restarts counting from 0 at the newly written source, with the prescaler restarted at the write.
- R7: A configuration write that changes the source code (bits 7:0) leaves the count value unchanged and restarts the prescaler at that edge.
- R8: A source code from 3 to 255 stops the count, which keeps its value.
- R9: The count is CNT_W bits wide (default 32) and wraps modulo 2^CNT_W. It is zero-extended to 32 bits on read.
- R10: Writes to the count offset (default 0x602) have no effect. Reads from any offset other than the configuration offset (default 0x600) or the count offset return 0.
- R11: Reading the configuration offset returns the source code in bits 7:0 and the hold bit in bit 8. All other bits read as 0.
- R12: A configuration write with the same source code and bit 8 clear, made while not held, does not restart the prescaler.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Register offset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_rdata | output | 32 | Read data, valid the cycle after the strobe |

## Verification
The count is first read back-to-back and after long waits at the nanosecond source. The wait at this source runs past the wrap point of a narrowed counter, which separates a wrong step size from a missing wrap. At the microsecond and millisecond sources, reads land just before and just after tick boundaries. These tell a prescaler that was restarted correctly apart from one that kept its old phase or was restarted when it should not have been, as happens with a same-source rewrite. A source switch is checked to carry the count over, and the hold write is checked to zero it. A write to the read-only count is made while the count is frozen by an unknown source code, so any effect of that write shows up directly in the read value.

// File: rtl/ts_timer_pkg.sv
package ts_timer_pkg;
   localparam int unsigned SRC_W    = 8;
   localparam int unsigned HOLD_BIT = 8;
   localparam logic [SRC_W-1:0] SRC_NS = 8'd0;
   localparam logic [SRC_W-1:0] SRC_US = 8'd1;
   localparam logic [SRC_W-1:0] SRC_MS = 8'd2;

   typedef struct packed {
      logic             hold;
      logic [SRC_W-1:0] src;
   } ts_cfg_t;
endpackage

// File: rtl/ts_tick_gen.sv
module ts_tick_gen #(
   parameter int unsigned US_CYCLES = 50,
   parameter int unsigned MS_PER_US = 1000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   output logic us_tick,
   output logic ms_tick
);
   localparam int unsigned CW = $clog2(US_CYCLES > 1 ? US_CYCLES : 2);
   localparam int unsigned UW = $clog2(MS_PER_US > 1 ? MS_PER_US : 2);
   localparam logic [CW-1:0] C_LAST = CW'(US_CYCLES - 1);
   localparam logic [UW-1:0] U_LAST = UW'(MS_PER_US - 1);

   logic [CW-1:0] cyc_q;

   assign us_tick = (cyc_q == C_LAST) && !restart;

   always_ff @(posedge clk) begin
      if (!rst_n || restart) cyc_q <= '0;
      else if (cyc_q == C_LAST) cyc_q <= '0;
      else cyc_q <= cyc_q + CW'(1);
   end

   generate
      if (MS_PER_US == 1) begin : g_ms_direct
         assign ms_tick = us_tick;
      end else begin : g_ms_div
         logic [UW-1:0] us_q;
         always_ff @(posedge clk) begin
            if (!rst_n || restart) us_q <= '0;
            else if (us_tick) us_q <= (us_q == U_LAST) ? '0 : us_q + UW'(1);
         end
         assign ms_tick = us_tick && (us_q == U_LAST);
      end
   endgenerate
endmodule

// File: rtl/ts_count_core.sv
module ts_count_core
   import ts_timer_pkg::*;
#(
   parameter int unsigned CNT_W   = 32,
   parameter int unsigned NS_STEP = 20
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic [SRC_W-1:0] src,
   input  logic             us_tick,
   input  logic             ms_tick,
   output logic [CNT_W-1:0] count
);
   logic [CNT_W-1:0] inc;

   always_comb begin
      case (src)
         SRC_NS:  inc = CNT_W'(NS_STEP);
         SRC_US:  inc = CNT_W'(us_tick);
         SRC_MS:  inc = CNT_W'(ms_tick);
         default: inc = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n || clear) count <= '0;
      else count <= count + inc;
   end
endmodule

// File: rtl/ts_bus_regs.sv
module ts_bus_regs
   import ts_timer_pkg::*;
#(
   parameter int unsigned ADDR_W  = 12,
   parameter logic [ADDR_W-1:0] CFG_OFS = 12'h600,
   parameter logic [ADDR_W-1:0] CNT_OFS = 12'h602,
   parameter int unsigned CNT_W   = 32,
   parameter bit          RD_REG  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [31:0]       bus_wdata,
   input  logic              bus_rd,
   output logic [31:0]       bus_rdata,
   input  logic [CNT_W-1:0]  count,
   output logic [SRC_W-1:0]  src_q,
   output logic              hold_q,
   output logic              restart,
   output logic              clear
);
   ts_cfg_t   wr_cfg;
   logic      cfg_wr;
   logic      unused_wbits;
   logic [31:0] rd_mux;

   assign wr_cfg       = ts_cfg_t'(bus_wdata[HOLD_BIT:0]);
   assign unused_wbits = ^bus_wdata[31:HOLD_BIT+1];
   assign cfg_wr       = bus_wr && (bus_addr == CFG_OFS);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         src_q  <= SRC_NS;
         hold_q <= 1'b0;
      end else if (cfg_wr) begin
         src_q  <= wr_cfg.src;
         hold_q <= wr_cfg.hold;
      end
   end

   assign clear   = hold_q || (cfg_wr && wr_cfg.hold);
   assign restart = clear || (cfg_wr && (wr_cfg.src != src_q));

   always_comb begin
      if (bus_addr == CFG_OFS)      rd_mux = 32'({hold_q, src_q});
      else if (bus_addr == CNT_OFS) rd_mux = 32'(count);
      else                          rd_mux = '0;
   end

   generate
      if (RD_REG) begin : g_rd_reg
         always_ff @(posedge clk) begin
            if (!rst_n) bus_rdata <= '0;
            else if (bus_rd) bus_rdata <= rd_mux;
         end
      end else begin : g_rd_comb
         assign bus_rdata = bus_rd ? rd_mux : '0;
      end
   endgenerate
endmodule

// File: rtl/ts_timer.sv
module ts_timer
   import ts_timer_pkg::*;
#(
   parameter int unsigned ADDR_W    = 12,
   parameter logic [ADDR_W-1:0] CFG_OFS = 12'h600,
   parameter logic [ADDR_W-1:0] CNT_OFS = 12'h602,
   parameter int unsigned CNT_W     = 32,
   parameter int unsigned NS_STEP   = 20,
   parameter int unsigned US_CYCLES = 50,
   parameter int unsigned MS_PER_US = 1000,
   parameter bit          RD_REG    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [31:0]       bus_wdata,
   input  logic              bus_rd,
   output logic [31:0]       bus_rdata
);
   generate
      if (CNT_W < 1 || CNT_W > 32) begin : g_bad_cnt_w
         $error("ts_timer: CNT_W must be 1..32");
      end
      if (US_CYCLES < 1 || MS_PER_US < 1) begin : g_bad_div
         $error("ts_timer: prescaler divisors must be at least 1");
      end
      if (CFG_OFS == CNT_OFS) begin : g_bad_map
         $error("ts_timer: register offsets collide");
      end
   endgenerate

   logic [SRC_W-1:0] src_q;
   logic             hold_q;
   logic             restart_w;
   logic             clr_w;
   logic             us_tick;
   logic             ms_tick;
   logic [CNT_W-1:0] count_q;

   ts_bus_regs #(
      .ADDR_W(ADDR_W), .CFG_OFS(CFG_OFS), .CNT_OFS(CNT_OFS),
      .CNT_W(CNT_W), .RD_REG(RD_REG)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
      .count(count_q), .src_q(src_q), .hold_q(hold_q),
      .restart(restart_w), .clear(clr_w)
   );

   ts_tick_gen #(.US_CYCLES(US_CYCLES), .MS_PER_US(MS_PER_US)) u_tick (
      .clk(clk), .rst_n(rst_n), .restart(restart_w),
      .us_tick(us_tick), .ms_tick(ms_tick)
   );

   ts_count_core #(.CNT_W(CNT_W), .NS_STEP(NS_STEP)) u_core (
      .clk(clk), .rst_n(rst_n), .clear(clr_w), .src(src_q),
      .us_tick(us_tick), .ms_tick(ms_tick), .count(count_q)
   );
endmodule

// File: rtl/ts_timer_chk.sv
module ts_timer_chk #(
   parameter int unsigned ADDR_W  = 12,
   parameter logic [ADDR_W-1:0] CFG_OFS = 12'h600,
   parameter int unsigned CNT_W   = 32,
   parameter int unsigned NS_STEP = 20,
   parameter bit          RD_REG  = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic [7:0]        src_q,
   input logic              hold_q,
   input logic              clr_w,
   input logic [CNT_W-1:0]  count_q,
   input logic              bus_rd,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [31:0]       bus_rdata
);
   // R5: a held configuration forces the count to zero
   a_r5_hold_zero: assert property (@(posedge clk) disable iff (!rst_n)
      hold_q |=> (count_q == '0));

   // R2: nanosecond source steps every edge
   a_r2_ns_step: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_w && src_q == 8'd0) |=> (count_q == $past(count_q) + CNT_W'(NS_STEP)));

   // R3: microsecond source never jumps by more than one
   a_r3_us_step: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_w && src_q == 8'd1) |=>
         (count_q == $past(count_q) || count_q == $past(count_q) + CNT_W'(1)));

   // R4: millisecond source never jumps by more than one
   a_r4_ms_step: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_w && src_q == 8'd2) |=>
         (count_q == $past(count_q) || count_q == $past(count_q) + CNT_W'(1)));

   // R8: unknown source codes freeze the count
   a_r8_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_w && src_q > 8'd2) |=> $stable(count_q));

   generate
      if (RD_REG) begin : g_rd_chk
         // R11: configuration read returns source and hold, upper bits clear
         a_r11_cfg_read: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_rd && bus_addr == CFG_OFS) |=>
               (bus_rdata[7:0] == $past(src_q) && bus_rdata[8] == $past(hold_q)
                && bus_rdata[31:9] == '0));
      end
   endgenerate
endmodule

bind ts_timer ts_timer_chk #(
   .ADDR_W(ADDR_W), .CFG_OFS(CFG_OFS), .CNT_W(CNT_W),
   .NS_STEP(NS_STEP), .RD_REG(RD_REG)
) u_chk (
   .clk(clk), .rst_n(rst_n), .src_q(src_q), .hold_q(hold_q), .clr_w(clr_w),
   .count_q(count_q), .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_rdata(bus_rdata)
);

// File: tb/sim_ts_timer.sv
module sim_ts_timer;
   localparam int unsigned CW  = 12;
   localparam int unsigned US  = 5;
   localparam int unsigned MSU = 4;
   localparam int unsigned STEP = 20;
   localparam logic [11:0] A_CFG = 12'h600;
   localparam logic [11:0] A_CNT = 12'h602;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic        bus_rd = 1'b0;
   logic [31:0] bus_rdata;

   int n_chk = 0;
   int n_bad = 0;
   int edge_n = 0;

   longint m_base = 0;
   int     m_edge = 0;
   int     m_src  = 0;
   bit     m_hold = 1'b0;

   int    exp_q[$];
   string tag_q[$];

   always #2 clk = ~clk;

   always @(posedge clk) if (rst_n) edge_n <= edge_n + 1;

   ts_timer #(.CNT_W(CW), .US_CYCLES(US), .MS_PER_US(MSU), .NS_STEP(STEP)) u0 (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata)
   );

   function automatic longint exp_at(int k);
      longint d, v;
      if (m_hold) return 0;
      d = k - m_edge;
      case (m_src)
         0: v = m_base + STEP * d;
         1: v = m_base + d / US;
         2: v = m_base + d / (US * MSU);
         default: v = m_base;
      endcase
      return v % (longint'(1) << CW);
   endfunction

   task automatic check(bit ok, string tag, int act, int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: got 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   task automatic wr(logic [11:0] a, int d);
      int w;
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      w = edge_n + 1;
      if (a == A_CFG) begin
         if (d[8]) begin
            m_base = 0; m_hold = 1'b1; m_edge = w; m_src = d & 255;
         end else if (m_hold) begin
            m_base = 0; m_hold = 1'b0; m_edge = w; m_src = d & 255;
         end else if ((d & 255) != m_src) begin
            m_base = exp_at(w); m_edge = w; m_src = d & 255;
         end
      end
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(logic [11:0] a, string tag);
      int r, e;
      bus_addr = a; bus_rd = 1'b1;
      r = edge_n + 1;
      if (a == A_CNT)      e = int'(exp_at(r - 1));
      else if (a == A_CFG) e = (int'(m_hold) << 8) | m_src;
      else                 e = 0;
      exp_q.push_back(e);
      tag_q.push_back(tag);
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin : monitor
      forever begin
         @(posedge clk);
         if (bus_rd) begin
            int e;
            string t;
            @(negedge clk);
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(bus_rdata == e, t, bus_rdata, e);
         end
      end
   end

   initial begin : watchdog
      #600000;
      n_bad++; n_chk++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin : driver
      idle(4);
      check(bus_rdata == 0, "R1 reset rdata", bus_rdata, 0);
      rst_n = 1'b1;
      rd(A_CFG, "R1 cfg after reset");
      rd(A_CNT, "R1 count after reset");
      idle(3);
      rd(A_CNT, "R2 ns step");
      rd(A_CNT, "R2 ns step back-to-back");
      idle(220);
      rd(A_CNT, "R9 wrap");
      wr(A_CFG, 32'h101);
      rd(A_CNT, "R5 held zero");
      idle(10);
      rd(A_CNT, "R5 still zero");
      rd(A_CFG, "R11 cfg shows hold+src");
      wr(A_CFG, 32'h001);
      idle(2);
      rd(A_CNT, "R6 restart from zero");
      idle(10);
      rd(A_CNT, "R3 us tick");
      idle(6);
      rd(A_CNT, "R3 us tick later");
      wr(A_CFG, 32'h001);
      idle(3);
      rd(A_CNT, "R12 same-src no restart");
      idle(1);
      rd(A_CNT, "R12 phase kept");
      wr(A_CFG, 32'h000);
      rd(A_CNT, "R7 count kept on switch");
      idle(2);
      rd(A_CNT, "R7 new rate");
      wr(A_CFG, 32'h002);
      idle(18);
      rd(A_CNT, "R4 ms before tick");
      rd(A_CNT, "R4 ms at tick");
      idle(25);
      rd(A_CNT, "R4 ms later");
      wr(A_CFG, 32'h0FF);
      rd(A_CFG, "R11 cfg unknown src");
      idle(20);
      rd(A_CNT, "R8 frozen");
      wr(A_CNT, 32'hABC);
      rd(A_CNT, "R10 count write ignored");
      rd(12'h604, "R10 unmapped read zero");
      idle(4);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule